// File: doc/BRIEF.md
# Segment Registers and Physical Address Generator

This block stores the four 16-bit segment bases of a segmented 16-bit processor and the 16-bit instruction pointer. It turns a segment and an offset into a 20-bit physical address. The segments are the code, data, stack and extra bases. The physical address is the segment value moved up by four bit positions plus the offset. The sum is truncated to 20 bits, so an address that passes FFFFFh wraps around to the bottom of the space.

The block has two address outputs.
- The fetch address always combines the code segment with the instruction pointer.
- The data address combines the segment picked by a 2-bit select with a separate offset input.

Fetch and branch logic moves the instruction pointer in three ways:
- An advance strobe adds the length of the current instruction.
- A near load replaces the pointer alone.
- A far load replaces both the code segment and the pointer in one cycle.

The pointer has no ordinary register write port. Its current value is available on an output so that it can be saved.

After reset the code segment is FFFFh and everything else is zero. The first fetch therefore comes from FFFF0h, near the top of memory.

All control and data pins are plain level or strobe signals and are sampled on the rising clock edge. The address outputs are combinational from the stored registers. There is no valid/ready handshake at any port, so the block never applies back-pressure. An address is usable in the same cycle that its select and offset are presented. A register load shows on the outputs after the next rising edge.

Top module: `seg_addr_gen`

## Requirements
- R1: While rst_n is low, and after it is released with no load, the code segment is FFFFh, the data, stack and extra segments are 0000h, and the instruction pointer is 0000h. The fetch address is therefore FFFF0h.
- R2: data_paddr equals ({segment, 4'h0} + {4'h0, data_off}) truncated to 20 bits, combinationally in the same cycle. For example, segment FFFFh with offset 0020h gives 00010h.
- R3: seg_sel picks the segment for data_paddr as follows: 00 extra, 01 code, 10 stack, 11 data.
- R4: A high es_ld, cs_ld, ss_ld or ds_ld writes its own wdata into that one segment at the rising edge. The new value shows on the address outputs after that edge. The other segments are unchanged.
- R5: With ip_adv high and no load strobe, the instruction pointer becomes ip + ip_len (ip_len is 3 bits, 0 to 7) modulo 65536 at the edge.
- R6: With near_ld high and far_ld low, the instruction pointer takes near_ip. The code segment is unchanged unless cs_ld is high.
- R7: far_ld writes far_cs into the code segment and far_ip into the instruction pointer at the same edge.
- R8: Priority for the instruction pointer is far_ld over near_ld over ip_adv. When far_ld and cs_ld are both high, far_cs is written rather than cs_wdata.
- R9: fetch_paddr equals ({code segment, 4'h0} + {4'h0, ip}) truncated to 20 bits, wrapping past FFFFFh.
- R10: ip_out shows the stored instruction pointer. With no ip_adv, near_ld or far_ld it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| es_ld | input | 1 | Write strobe, extra segment |
| es_wdata | input | 16 | Value for the extra segment |
| cs_ld | input | 1 | Write strobe, code segment |
| cs_wdata | input | 16 | Value for the code segment |
| ss_ld | input | 1 | Write strobe, stack segment |
| ss_wdata | input | 16 | Value for the stack segment |
| ds_ld | input | 1 | Write strobe, data segment |
| ds_wdata | input | 16 | Value for the data segment |
| seg_sel | input | 2 | Segment choice for data_paddr (00 extra, 01 code, 10 stack, 11 data) |
| data_off | input | 16 | Offset for the data address |
| data_paddr | output | 20 | Physical address of the data access |
| ip_adv | input | 1 | Advance the instruction pointer by ip_len |
| ip_len | input | 3 | Instruction length in bytes |
| near_ld | input | 1 | Load the instruction pointer from near_ip |
| near_ip | input | 16 | Near target offset |
| far_ld | input | 1 | Load code segment and instruction pointer together |
| far_cs | input | 16 | Far target code segment |
| far_ip | input | 16 | Far target offset |
| fetch_paddr | output | 20 | Physical address of the next instruction fetch |
| ip_out | output | 16 | Current instruction pointer |

## Verification
Directed patterns run first.
- A reset check confirms the FFFF0h start address and zero bases.
- One distinct value is loaded into each segment and every select code is then read back. This shows that each code reaches its own register and that a load touches only one register.
- A code segment of FFFFh with a non-zero offset, and an instruction pointer near FFFFh advanced past the top, separate a correct wrapping sum from a 21-bit or saturating one.
- All pointer strobes are raised in the same cycle, together with cs_ld. This shows whether the stated priority holds.

Seeded random cycles then mix segment loads, strobes, lengths, selects and offsets. They catch carries between the shifted base and the offset that the directed values miss.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_id_e;

  localparam int NUM_SEG = 4;
endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SEG-1:0]            ld_i,
  input  logic [NUM_SEG-1:0][SEG_W-1:0] wdata_i,
  output logic [NUM_SEG-1:0][SEG_W-1:0] seg_o
);
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL =
      (g == int'(SEG_CODE)) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
    logic [SEG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)       q <= RST_VAL;
      else if (ld_i[g]) q <= wdata_i[g];
    end
    assign seg_o[g] = q;
  end
endmodule

// File: rtl/ip_ctrl.sv
module ip_ctrl #(
  parameter int IP_W  = 16,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             near_i,
  input  logic [IP_W-1:0]  near_ip_i,
  input  logic             far_i,
  input  logic [IP_W-1:0]  far_ip_i,
  output logic [IP_W-1:0]  ip_o
);
  logic [IP_W-1:0] ip_q, ip_d;

  always_comb begin
    ip_d = ip_q;
    if (far_i)       ip_d = far_ip_i;
    else if (near_i) ip_d = near_ip_i;
    else if (adv_i)  ip_d = ip_q + IP_W'(len_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ip_q <= '0;
    else        ip_q <= ip_d;
  end

  assign ip_o = ip_q;
endmodule

// File: rtl/paddr_form.sv
module paddr_form #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PA_W-1:0]  paddr_o
);
  localparam int SHIFT = PA_W - SEG_W;

  logic [PA_W-1:0] base;
  logic [PA_W-1:0] ext_off;

  assign base    = {seg_i, {SHIFT{1'b0}}};
  assign ext_off = PA_W'(off_i);
  assign paddr_o = base + ext_off;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             es_ld,
  input  logic [SEG_W-1:0] es_wdata,
  input  logic             cs_ld,
  input  logic [SEG_W-1:0] cs_wdata,
  input  logic             ss_ld,
  input  logic [SEG_W-1:0] ss_wdata,
  input  logic             ds_ld,
  input  logic [SEG_W-1:0] ds_wdata,
  input  logic [1:0]       seg_sel,
  input  logic [OFF_W-1:0] data_off,
  output logic [PA_W-1:0]  data_paddr,
  input  logic             ip_adv,
  input  logic [LEN_W-1:0] ip_len,
  input  logic             near_ld,
  input  logic [OFF_W-1:0] near_ip,
  input  logic             far_ld,
  input  logic [SEG_W-1:0] far_cs,
  input  logic [OFF_W-1:0] far_ip,
  output logic [PA_W-1:0]  fetch_paddr,
  output logic [OFF_W-1:0] ip_out
);
  logic [NUM_SEG-1:0]            seg_ld;
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_wd;
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [SEG_W-1:0]              data_seg;

  // A far transfer owns the code segment write port
  assign seg_ld[int'(SEG_EXTRA)] = es_ld;
  assign seg_ld[int'(SEG_CODE)]  = cs_ld | far_ld;
  assign seg_ld[int'(SEG_STACK)] = ss_ld;
  assign seg_ld[int'(SEG_DATA)]  = ds_ld;

  assign seg_wd[int'(SEG_EXTRA)] = es_wdata;
  assign seg_wd[int'(SEG_CODE)]  = far_ld ? far_cs : cs_wdata;
  assign seg_wd[int'(SEG_STACK)] = ss_wdata;
  assign seg_wd[int'(SEG_DATA)]  = ds_wdata;

  seg_bank #(.SEG_W(SEG_W)) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_i    (seg_ld),
    .wdata_i (seg_wd),
    .seg_o   (seg_q)
  );

  ip_ctrl #(.IP_W(OFF_W), .LEN_W(LEN_W)) ipc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (ip_adv),
    .len_i     (ip_len),
    .near_i    (near_ld),
    .near_ip_i (near_ip),
    .far_i     (far_ld),
    .far_ip_i  (far_ip),
    .ip_o      (ip_out)
  );

  assign data_seg = seg_q[seg_sel];

  paddr_form #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) fetch_form_i (
    .seg_i   (seg_q[int'(SEG_CODE)]),
    .off_i   (ip_out),
    .paddr_o (fetch_paddr)
  );

  paddr_form #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) data_form_i (
    .seg_i   (data_seg),
    .off_i   (data_off),
    .paddr_o (data_paddr)
  );
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ip_adv,
  input logic [LEN_W-1:0] ip_len,
  input logic             near_ld,
  input logic [OFF_W-1:0] near_ip,
  input logic             far_ld,
  input logic [OFF_W-1:0] far_ip,
  input logic [OFF_W-1:0] data_off,
  input logic [PA_W-1:0]  data_paddr,
  input logic [PA_W-1:0]  fetch_paddr,
  input logic [OFF_W-1:0] ip_out
);
  localparam int SHIFT = PA_W - SEG_W;

  logic [PA_W-1:0] fetch_base;
  assign fetch_base = fetch_paddr - PA_W'(ip_out);

  // R1
  reset_start_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (fetch_paddr == {{SEG_W{1'b1}}, {SHIFT{1'b0}}}) && (ip_out == '0));

  // R5
  ip_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_adv && !near_ld && !far_ld) |=> ip_out == OFF_W'($past(ip_out) + OFF_W'($past(ip_len))));

  // R6
  near_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (near_ld && !far_ld) |=> ip_out == $past(near_ip));

  // R7
  far_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    far_ld |=> ip_out == $past(far_ip));

  // R10
  ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ip_adv && !near_ld && !far_ld) |=> $stable(ip_out));

  // R9
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_base[SHIFT-1:0] == '0);

  // R2
  data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_paddr[SHIFT-1:0] == data_off[SHIFT-1:0]);
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .LEN_W(LEN_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ip_adv      (ip_adv),
  .ip_len      (ip_len),
  .near_ld     (near_ld),
  .near_ip     (near_ip),
  .far_ld      (far_ld),
  .far_ip      (far_ip),
  .data_off    (data_off),
  .data_paddr  (data_paddr),
  .fetch_paddr (fetch_paddr),
  .ip_out      (ip_out)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        es_ld, cs_ld, ss_ld, ds_ld;
  logic [15:0] es_wdata, cs_wdata, ss_wdata, ds_wdata;
  logic [1:0]  seg_sel;
  logic [15:0] data_off;
  logic [19:0] data_paddr, fetch_paddr;
  logic        ip_adv, near_ld, far_ld;
  logic [2:0]  ip_len;
  logic [15:0] near_ip, far_cs, far_ip, ip_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model: index 0 extra, 1 code, 2 stack, 3 data
  logic [15:0] seg_m [4];
  logic [15:0] ip_m;

  always #4ns clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .es_ld(es_ld), .es_wdata(es_wdata), .cs_ld(cs_ld), .cs_wdata(cs_wdata),
    .ss_ld(ss_ld), .ss_wdata(ss_wdata), .ds_ld(ds_ld), .ds_wdata(ds_wdata),
    .seg_sel(seg_sel), .data_off(data_off), .data_paddr(data_paddr),
    .ip_adv(ip_adv), .ip_len(ip_len), .near_ld(near_ld), .near_ip(near_ip),
    .far_ld(far_ld), .far_cs(far_cs), .far_ip(far_ip),
    .fetch_paddr(fetch_paddr), .ip_out(ip_out)
  );

  function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
    logic [19:0] r;
    r = {s, 4'h0} + {4'h0, o};
    return r;
  endfunction

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic idle();
    es_ld = 0; cs_ld = 0; ss_ld = 0; ds_ld = 0;
    ip_adv = 0; near_ld = 0; far_ld = 0;
  endtask

  // advance one edge, update the model, return at the next falling edge
  task automatic tick();
    @(posedge clk);
    if (rst_n) begin
      if (es_ld) seg_m[0] = es_wdata;
      if (far_ld) seg_m[1] = far_cs; else if (cs_ld) seg_m[1] = cs_wdata;
      if (ss_ld) seg_m[2] = ss_wdata;
      if (ds_ld) seg_m[3] = ds_wdata;
      if (far_ld) ip_m = far_ip;
      else if (near_ld) ip_m = near_ip;
      else if (ip_adv) ip_m = ip_m + 16'(ip_len);
    end
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < 4; s++) begin
      seg_sel = 2'(s);
      data_off = 16'h0000;
      #1;
      chk(tag, data_paddr, pa(seg_m[s], 16'h0000));
    end
    chk(tag, fetch_paddr, pa(seg_m[1], ip_m));
    chk(tag, {4'h0, ip_out}, {4'h0, ip_m});
  endtask

  initial begin
    #(8ns * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    {es_wdata, cs_wdata, ss_wdata, ds_wdata} = '0;
    near_ip = 0; far_cs = 0; far_ip = 0; ip_len = 0;
    seg_sel = 0; data_off = 0;
    rst_n = 0;
    seg_m[0] = 16'h0000; seg_m[1] = 16'hFFFF; seg_m[2] = 16'h0000; seg_m[3] = 16'h0000;
    ip_m = 16'h0000;
    repeat (3) tick();
    // R1 during reset, strobes ignored
    cs_ld = 1; cs_wdata = 16'h1234; far_ld = 1; far_ip = 16'h5555;
    tick();
    idle();
    check_all("R1 in reset");
    rst_n = 1;
    tick();
    chk("R1 fetch start", fetch_paddr, 20'hFFFF0);
    check_all("R1 after release");

    // R3 / R4: distinct value per segment, load one at a time
    es_ld = 1; es_wdata = 16'h1000; tick(); idle();
    check_all("R4 extra only");
    ss_ld = 1; ss_wdata = 16'h2000; tick(); idle();
    ds_ld = 1; ds_wdata = 16'h3000; tick(); idle();
    cs_ld = 1; cs_wdata = 16'h4000; tick(); idle();
    seg_sel = 2'b00; data_off = 16'h0005; #1; chk("R3 sel 00 extra", data_paddr, 20'h10005);
    seg_sel = 2'b01; #1; chk("R3 sel 01 code", data_paddr, 20'h40005);
    seg_sel = 2'b10; #1; chk("R3 sel 10 stack", data_paddr, 20'h20005);
    seg_sel = 2'b11; #1; chk("R3 sel 11 data", data_paddr, 20'h30005);

    // R2 wrap past top
    ds_ld = 1; ds_wdata = 16'hFFFF; tick(); idle();
    seg_sel = 2'b11; data_off = 16'h0020; #1;
    chk("R2 wrap", data_paddr, 20'h00010);
    data_off = 16'hFFFF; #1;
    chk("R2 max", data_paddr, 20'h0FFEF);

    // R7 far load, R9 fetch wrap
    far_ld = 1; far_cs = 16'hFFFF; far_ip = 16'h0025; tick(); idle();
    chk("R9 fetch wrap", fetch_paddr, 20'h00015);
    chk("R7 far ip", {4'h0, ip_out}, 20'h00025);

    // R5 advance wrap
    near_ld = 1; near_ip = 16'hFFFE; tick(); idle();
    chk("R6 near ip", {4'h0, ip_out}, 20'h0FFFE);
    check_all("R6 code kept");
    ip_adv = 1; ip_len = 3'd3; tick(); idle();
    chk("R5 ip wrap", {4'h0, ip_out}, 20'h00001);
    ip_adv = 1; ip_len = 3'd0; tick(); idle();
    chk("R5 zero len", {4'h0, ip_out}, 20'h00001);

    // R10 hold
    repeat (3) tick();
    chk("R10 hold", {4'h0, ip_out}, 20'h00001);

    // R8 priority: everything at once
    far_ld = 1; near_ld = 1; ip_adv = 1; cs_ld = 1;
    far_cs = 16'hABCD; far_ip = 16'h0100; near_ip = 16'h0200; ip_len = 3'd7; cs_wdata = 16'h1111;
    tick(); idle();
    chk("R8 far over near/adv", {4'h0, ip_out}, 20'h00100);
    chk("R8 far over cs_ld", fetch_paddr, 20'hABDD0);
    near_ld = 1; ip_adv = 1; near_ip = 16'h0300; ip_len = 3'd5; tick(); idle();
    chk("R8 near over adv", {4'h0, ip_out}, 20'h00300);
    check_all("R8 model");

    // random phase
    for (int i = 0; i < 600; i++) begin
      es_ld = ($urandom % 8) == 0; es_wdata = 16'($urandom);
      cs_ld = ($urandom % 8) == 0; cs_wdata = 16'($urandom);
      ss_ld = ($urandom % 8) == 0; ss_wdata = 16'($urandom);
      ds_ld = ($urandom % 8) == 0; ds_wdata = 16'($urandom);
      ip_adv = ($urandom % 2) == 0; ip_len = 3'($urandom);
      near_ld = ($urandom % 10) == 0; near_ip = 16'($urandom);
      far_ld = ($urandom % 12) == 0; far_cs = 16'($urandom); far_ip = 16'($urandom);
      seg_sel = 2'($urandom); data_off = 16'($urandom);
      #1;
      chk("R2 random data", data_paddr, pa(seg_m[seg_sel], data_off));
      chk("R9 random fetch", fetch_paddr, pa(seg_m[1], ip_m));
      chk("R5 random ip", {4'h0, ip_out}, {4'h0, ip_m});
      tick();
    end
    idle();
    check_all("R4 final");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule